// File: doc/BRIEF.md
# YUV to RGB Colour-Space Converter

This block converts a stream of 8-bit luma and chroma samples into 8-bit red, green and blue, one sample per clock with no back-pressure. The luma sample first receives a signed offset and is clamped into the 8-bit range. It is then scaled by a shared unsigned luma gain. Each colour channel adds its own signed contributions from the two chroma samples, which are centred on 128. The sum is rounded to the nearest integer and clamped to 0..255.

The nine coefficients live in registers that a simple write port loads. Each coefficient has its own fixed-point format and is packed at the low end of a 16-bit write word. A sideband field travels beside each sample with the same three-cycle latency, so the caller can tag pixels, for example with line or frame markers. Chroma upsampling and memory fetch belong to the blocks ahead of this one.

Top module: `yuv2rgb_csc`

## Requirements
- R1: A sample presented with `in_vld` high in cycle t produces `out_vld` high in cycle t+3. `out_vld` is low in every cycle whose sample three cycles earlier was not valid.
- R2: `out_side` in cycle t+3 equals `in_side` in cycle t, whether or not the sample is valid.
- R3: The luma offset lives at address 0, bits 7:0, as a signed 8-bit integer. The block forms Y + offset and clamps it to 0..255 before scaling.
- R4: U and V are each reduced by 128, giving a signed value in -128..127, before they are multiplied.
- R5: Red = clamp(round((gain·Yc + cu_r·Uc + cv_r·Vc) / 256)). cu_r is at address 2 and cv_r at address 3. Both are signed with 2 integer and 8 fraction bits, taken from bits 10:0.
- R6: Green uses cu_g at address 4 and cv_g at address 5. Both are signed with 1 integer and 8 fraction bits, taken from bits 9:0.
- R7: Blue uses cu_b at address 6 and cv_b at address 7. Both use the same format as the red coefficients.
- R8: The luma gain is at address 1. It is unsigned with 2 integer and 8 fraction bits, taken from bits 9:0.
- R9: The final sum is rounded half-up by adding 128 and dividing by 256 with floor. The result is then clamped to 0..255.
- R10: Write-data bits above a coefficient's format width have no effect.
- R11: A write applied at a clock edge affects only samples accepted at later edges. A sample accepted at the same edge, or earlier, uses the previous value.
- R12: Reset clears `out_vld` and `out_side`. It sets the gain to 1.0 (256) and every other coefficient to 0, so R = G = B = Y.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 3 | Coefficient select |
| cfg_wdata | input | 16 | Coefficient value, LSB-justified |
| in_vld | input | 1 | Input sample valid |
| in_y | input | 8 | Luma sample |
| in_u | input | 8 | Blue-difference chroma sample |
| in_v | input | 8 | Red-difference chroma sample |
| in_side | input | SIDE_W | Sideband carried with the sample |
| out_vld | output | 1 | Output pixel valid |
| out_r | output | 8 | Red result |
| out_g | output | 8 | Green result |
| out_b | output | 8 | Blue result |
| out_side | output | SIDE_W | Sideband, delayed to match |

## Verification
A wrongly decoded or wrongly sign-extended coefficient register shows up as a wrong colour on the first valid pixel accepted after the write, three cycles later. A stale pipeline product shows up the same way. A slip in the valid or sideband delay misaligns `out_vld` or `out_side` in the very next output cycle. A clamp or rounding fault appears only at the extremes, so the stimulus drives offsets, gains and chroma to their limits and to the rounding half-points. Random coefficient writes are mixed between valid pixels to expose writes that leak into samples already in flight.

// File: rtl/csc_pkg.sv
`timescale 1ns/1ps
package csc_pkg;
    localparam int PIX_W  = 8;
    localparam int FRAC_W = 8;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 3;
    localparam int CH_N   = 3;
    localparam int CH_G   = 1;
    localparam int PIPE_N = 3;

    localparam int YOF_W  = PIX_W;
    localparam int KY_W   = FRAC_W + 2;
    localparam int KW_W   = FRAC_W + 3;
    localparam int KN_W   = FRAC_W + 2;

    localparam int LUMA_W = PIX_W + 2;
    localparam int PROD_W = KW_W + PIX_W + 1;
    localparam int ACC_W  = PROD_W + 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_YOF = 3'd0,
        REG_KY  = 3'd1
    } csc_reg_e;

    typedef struct packed {
        logic [YOF_W-1:0]           yof;
        logic [KY_W-1:0]            ky;
        logic [CH_N-1:0][KW_W-1:0]  ku;
        logic [CH_N-1:0][KW_W-1:0]  kv;
    } csc_coef_t;

    typedef struct packed {
        logic [PROD_W-1:0]            yp;
        logic [CH_N-1:0][PROD_W-1:0]  up;
        logic [CH_N-1:0][PROD_W-1:0]  vp;
    } csc_front_t;

    localparam logic [KY_W-1:0] KY_UNITY = KY_W'(1 << FRAC_W);
    localparam csc_coef_t COEF_RST = '{yof: '0, ky: KY_UNITY, ku: '0, kv: '0};
endpackage

// File: rtl/csc_coef_regs.sv
`timescale 1ns/1ps
module csc_coef_regs
    import csc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output csc_coef_t         coef_q
);
    csc_coef_t coef_d;

    // Narrow (s.1.8) words are sign-extended so every channel shares one width.
    function automatic logic [KW_W-1:0] unpack_k(input logic [REG_W-1:0] w, input bit narrow);
        if (narrow) return {w[KN_W-1], w[KN_W-1:0]};
        return w[KW_W-1:0];
    endfunction

    always_comb begin
        coef_d = coef_q;
        if (we) begin
            if (addr == REG_YOF) coef_d.yof = wdata[YOF_W-1:0];
            if (addr == REG_KY)  coef_d.ky  = wdata[KY_W-1:0];
            for (int c = 0; c < CH_N; c++) begin
                if (addr == ADDR_W'(2 + 2 * c)) coef_d.ku[c] = unpack_k(wdata, c == CH_G);
                if (addr == ADDR_W'(3 + 2 * c)) coef_d.kv[c] = unpack_k(wdata, c == CH_G);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) coef_q <= COEF_RST;
        else        coef_q <= coef_d;
    end
endmodule

// File: rtl/csc_front.sv
`timescale 1ns/1ps
module csc_front
    import csc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] y,
    input  logic [PIX_W-1:0] u,
    input  logic [PIX_W-1:0] v,
    input  csc_coef_t        coef,
    output csc_front_t       st_q
);
    csc_front_t st_d;
    logic signed [LUMA_W-1:0] ysum;
    logic [PIX_W-1:0]         yclip;
    logic signed [PIX_W-1:0]  uc;
    logic signed [PIX_W-1:0]  vc;

    always_comb begin
        ysum = LUMA_W'($signed({1'b0, y})) + LUMA_W'($signed(coef.yof));
        if (ysum[LUMA_W-1])                 yclip = '0;
        else if (|ysum[LUMA_W-2:PIX_W])     yclip = '1;
        else                                yclip = ysum[PIX_W-1:0];

        // Flipping the MSB subtracts the mid-code from an 8-bit sample.
        uc = {~u[PIX_W-1], u[PIX_W-2:0]};
        vc = {~v[PIX_W-1], v[PIX_W-2:0]};

        st_d.yp = PROD_W'($signed({1'b0, yclip})) * PROD_W'($signed({1'b0, coef.ky}));
        for (int c = 0; c < CH_N; c++) begin
            st_d.up[c] = PROD_W'($signed(coef.ku[c])) * PROD_W'(uc);
            st_d.vp[c] = PROD_W'($signed(coef.kv[c])) * PROD_W'(vc);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/csc_chan_tail.sv
`timescale 1ns/1ps
module csc_chan_tail
    import csc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [PROD_W-1:0] yp,
    input  logic signed [PROD_W-1:0] up,
    input  logic signed [PROD_W-1:0] vp,
    output logic [PIX_W-1:0]         pix_q
);
    localparam int HALF = 1 << (FRAC_W - 1);

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
        logic [PIX_W-1:0]        pix;
    } tail_t;

    tail_t st_d, st_q;
    logic signed [ACC_W-1:0] rnd;
    logic signed [ACC_W-1:0] sh;

    always_comb begin
        st_d.acc = ACC_W'(yp) + ACC_W'(up) + ACC_W'(vp);
        rnd = st_q.acc + ACC_W'(HALF);
        sh  = rnd >>> FRAC_W;
        if (sh[ACC_W-1])                    st_d.pix = '0;
        else if (|sh[ACC_W-2:PIX_W])        st_d.pix = '1;
        else                                st_d.pix = sh[PIX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pix_q = st_q.pix;
endmodule

// File: rtl/yuv2rgb_csc.sv
`timescale 1ns/1ps
module yuv2rgb_csc
    import csc_pkg::*;
#(
    parameter int SIDE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [15:0]       cfg_wdata,
    input  logic              in_vld,
    input  logic [7:0]        in_y,
    input  logic [7:0]        in_u,
    input  logic [7:0]        in_v,
    input  logic [SIDE_W-1:0] in_side,
    output logic              out_vld,
    output logic [7:0]        out_r,
    output logic [7:0]        out_g,
    output logic [7:0]        out_b,
    output logic [SIDE_W-1:0] out_side
);
    typedef struct packed {
        logic              vld;
        logic [SIDE_W-1:0] side;
    } sb_t;

    csc_coef_t                   coef;
    csc_front_t                  front_q;
    logic [CH_N-1:0][PIX_W-1:0]  pix;
    sb_t  [PIPE_N-1:0]           sb_d, sb_q;

    csc_coef_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .coef_q (coef)
    );

    csc_front u_front (
        .clk   (clk),
        .rst_n (rst_n),
        .y     (in_y),
        .u     (in_u),
        .v     (in_v),
        .coef  (coef),
        .st_q  (front_q)
    );

    for (genvar c = 0; c < CH_N; c++) begin : g_chan
        csc_chan_tail u_tail (
            .clk   (clk),
            .rst_n (rst_n),
            .yp    (front_q.yp),
            .up    (front_q.up[c]),
            .vp    (front_q.vp[c]),
            .pix_q (pix[c])
        );
    end

    always_comb begin
        sb_d[0] = '{vld: in_vld, side: in_side};
        for (int i = 1; i < PIPE_N; i++) sb_d[i] = sb_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sb_q <= '0;
        else        sb_q <= sb_d;
    end

    assign out_vld  = sb_q[PIPE_N-1].vld;
    assign out_side = sb_q[PIPE_N-1].side;
    assign out_r    = pix[0];
    assign out_g    = pix[1];
    assign out_b    = pix[2];
endmodule

// File: rtl/csc_checker.sv
`timescale 1ns/1ps
module csc_checker #(
    parameter int SIDE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              in_vld,
    input logic [7:0]        in_y,
    input logic [7:0]        in_u,
    input logic [7:0]        in_v,
    input logic [SIDE_W-1:0] in_side,
    input logic              out_vld,
    input logic [7:0]        out_r,
    input logic [7:0]        out_g,
    input logic [7:0]        out_b,
    input logic [SIDE_W-1:0] out_side
);
    logic [1:0]  age_q;
    logic [3:0]  hold_q;
    logic [23:0] prev_q;
    logic [23:0] cur;

    assign cur = {in_y, in_u, in_v};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q  <= '0;
            hold_q <= '0;
            prev_q <= '0;
        end else begin
            if (age_q != 2'd3) age_q <= age_q + 2'd1;
            prev_q <= cur;
            if (in_vld && cur == prev_q && !cfg_we) begin
                if (hold_q != 4'hF) hold_q <= hold_q + 4'd1;
            end else begin
                hold_q <= '0;
            end
        end
    end

    a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (out_vld == $past(in_vld, 3)));

    a_r2_side_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (out_side == $past(in_side, 3)));

    a_r12_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (!out_vld && out_side == '0));

    // R11: an unchanged stream with no writes cannot change the colour.
    a_r11_quiet_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q >= 4'd5 && out_vld) |-> ($stable(out_r) && $stable(out_g) && $stable(out_b)));
endmodule

bind yuv2rgb_csc csc_checker #(.SIDE_W(SIDE_W)) u_csc_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .in_vld   (in_vld),
    .in_y     (in_y),
    .in_u     (in_u),
    .in_v     (in_v),
    .in_side  (in_side),
    .out_vld  (out_vld),
    .out_r    (out_r),
    .out_g    (out_g),
    .out_b    (out_b),
    .out_side (out_side)
);

// File: tb/test_yuv2rgb_csc.sv
`timescale 1ns/1ps
module test_yuv2rgb_csc;
    localparam int SIDE_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b1;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_addr = '0;
    logic [15:0]       cfg_wdata = '0;
    logic              in_vld = 1'b0;
    logic [7:0]        in_y = '0, in_u = 8'd128, in_v = 8'd128;
    logic [SIDE_W-1:0] in_side = '0;
    logic              out_vld;
    logic [7:0]        out_r, out_g, out_b;
    logic [SIDE_W-1:0] out_side;

    int checks = 0;
    int fails  = 0;

    int m_yof, m_ky;
    int m_ku[3], m_kv[3];

    bit    p_vld[3];
    int    p_side[3], p_r[3], p_g[3], p_b[3];
    string p_tag[3];

    always #4 clk = ~clk;

    yuv2rgb_csc #(.SIDE_W(SIDE_W)) i_yuv2rgb_csc (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_vld(in_vld), .in_y(in_y), .in_u(in_u),
        .in_v(in_v), .in_side(in_side), .out_vld(out_vld), .out_r(out_r),
        .out_g(out_g), .out_b(out_b), .out_side(out_side)
    );

    function automatic int sx(int val, int w);
        int m = val & ((1 << w) - 1);
        if (m >= (1 << (w - 1))) m -= (1 << w);
        return m;
    endfunction

    function automatic int sat8(int x);
        if (x < 0) return 0;
        if (x > 255) return 255;
        return x;
    endfunction

    function automatic int chan(int yc, int uc, int vc, int ku, int kv);
        int acc = m_ky * yc + ku * uc + kv * vc;
        return sat8((acc + 128) >>> 8);
    endfunction

    task automatic model_reset();
        m_yof = 0; m_ky = 256;
        for (int c = 0; c < 3; c++) begin m_ku[c] = 0; m_kv[c] = 0; end
        for (int i = 0; i < 3; i++) begin
            p_vld[i] = 0; p_side[i] = 0; p_r[i] = 0; p_g[i] = 0; p_b[i] = 0; p_tag[i] = "";
        end
    endtask

    task automatic model_write(int a, int d);
        case (a)
            0: m_yof = sx(d, 8);
            1: m_ky  = d & 16'h3FF;
            2: m_ku[0] = sx(d, 11);
            3: m_kv[0] = sx(d, 11);
            4: m_ku[1] = sx(d, 10);
            5: m_kv[1] = sx(d, 10);
            6: m_ku[2] = sx(d, 11);
            default: m_kv[2] = sx(d, 11);
        endcase
    endtask

    task automatic chk(bit ok, string req, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, tag, act, exp);
        end
    endtask

    task automatic compare();
        chk(out_vld == p_vld[2], "R1", p_tag[2], int'(out_vld), int'(p_vld[2]));
        chk(int'(out_side) == p_side[2], "R2", p_tag[2], int'(out_side), p_side[2]);
        if (p_vld[2]) begin
            chk(int'(out_r) == p_r[2], "R5", p_tag[2], int'(out_r), p_r[2]);
            chk(int'(out_g) == p_g[2], "R6", p_tag[2], int'(out_g), p_g[2]);
            chk(int'(out_b) == p_b[2], "R7", p_tag[2], int'(out_b), p_b[2]);
        end
    endtask

    // Called just after a falling edge; returns just after the next one.
    task automatic cyc(bit v, int y, int u, int vv, bit we, int a, int d, string tag);
        int yc, uc, vc, sd;
        sd = int'($urandom_range(0, (1 << SIDE_W) - 1));
        in_vld = v; in_y = 8'(y); in_u = 8'(u); in_v = 8'(vv); in_side = SIDE_W'(sd);
        cfg_we = we; cfg_addr = 3'(a); cfg_wdata = 16'(d);
        @(posedge clk);
        for (int i = 2; i > 0; i--) begin
            p_vld[i] = p_vld[i-1]; p_side[i] = p_side[i-1]; p_tag[i] = p_tag[i-1];
            p_r[i] = p_r[i-1]; p_g[i] = p_g[i-1]; p_b[i] = p_b[i-1];
        end
        yc = sat8((y & 255) + m_yof);
        uc = (u & 255) - 128;
        vc = (vv & 255) - 128;
        p_vld[0] = v; p_side[0] = sd; p_tag[0] = tag;
        p_r[0] = chan(yc, uc, vc, m_ku[0], m_kv[0]);
        p_g[0] = chan(yc, uc, vc, m_ku[1], m_kv[1]);
        p_b[0] = chan(yc, uc, vc, m_ku[2], m_kv[2]);
        if (we) model_write(a, d);
        @(negedge clk);
        compare();
    endtask

    task automatic px(int y, int u, int v, string tag);
        cyc(1, y, u, v, 0, 0, 0, tag);
    endtask

    task automatic wr(int a, int d, string tag);
        cyc(0, 0, 128, 128, 1, a, d, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        model_reset();
        #2 rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(out_vld == 1'b0, "R12", "reset", int'(out_vld), 0);
            chk(out_side == '0, "R12", "reset", int'(out_side), 0);
        end
        rst_n = 1'b1;

        // R12: reset coefficients pass luma to all channels
        px(0, 10, 240, "R12 identity");
        px(77, 255, 0, "R12 identity");
        px(255, 0, 0, "R12 identity");
        px(130, 128, 128, "R12 identity");

        // R3: inner luma clamp in both directions
        wr(0, 127, "R3");
        px(200, 128, 128, "R3 high clamp");
        px(100, 128, 128, "R3 offset");
        wr(0, 16'h0080, "R3");
        px(100, 128, 128, "R3 low clamp");
        px(255, 128, 128, "R3 negative offset");
        wr(0, 0, "R3");

        // R8: gain extremes
        wr(1, 1023, "R8");
        px(255, 128, 128, "R8 max gain");
        px(64, 128, 128, "R8 overflow");
        px(32, 128, 128, "R8 scaled");
        wr(1, 0, "R8");
        px(200, 128, 128, "R8 zero gain");

        // R9: rounding half-up and low clamp
        wr(1, 128, "R9");
        px(1, 128, 128, "R9 half");
        px(3, 128, 128, "R9 half");
        px(254, 128, 128, "R9 even");
        wr(1, 0, "R9");
        wr(2, 16'h07FF, "R9");
        px(0, 255, 128, "R9 tiny negative");
        px(0, 0, 128, "R9 tiny positive");

        // R4: chroma centring
        wr(2, 256, "R4");
        px(0, 200, 128, "R4 above centre");
        px(0, 128, 128, "R4 at centre");
        px(0, 0, 128, "R4 below centre");

        // R5..R7: a typical limited-range matrix
        wr(0, 16'h00F0, "R5");
        wr(1, 298, "R8");
        wr(2, 0, "R5");
        wr(3, 409, "R5");
        wr(4, (-100) & 16'h3FF, "R6");
        wr(5, (-208) & 16'h3FF, "R6");
        wr(6, 516, "R7");
        wr(7, 0, "R7");
        px(16, 128, 128, "R5 black");
        px(235, 128, 128, "R5 white");
        px(81, 90, 240, "R5 red");
        px(145, 54, 34, "R6 green");
        px(41, 240, 110, "R7 blue");
        px(255, 255, 255, "R7 extremes");
        px(0, 0, 0, "R7 extremes");

        // R6: narrow format sign and range
        wr(5, 16'h0200, "R6");
        wr(4, 16'h01FF, "R6");
        px(128, 0, 255, "R6 narrow");
        px(128, 255, 0, "R6 narrow");

        // R10: bits above each format are ignored
        wr(0, 16'hAB10, "R10");
        wr(3, 16'hF800 | 300, "R10");
        wr(4, 16'hFC00 | 50, "R10");
        wr(1, 16'hFC00 | 256, "R10");
        px(120, 60, 200, "R10 masked");
        px(60, 200, 30, "R10 masked");

        // R11: write on the same edge as a pixel
        cyc(1, 100, 50, 200, 1, 1, 512, "R11 same edge");
        px(100, 50, 200, "R11 after write");
        cyc(1, 100, 50, 200, 1, 3, (-300) & 16'h7FF, "R11 same edge");
        px(100, 50, 200, "R11 after write");

        // Random stream with interleaved writes (R1, R2, R5..R7)
        for (int n = 0; n < 3000; n++) begin
            bit w = ($urandom_range(0, 7) == 0);
            bit v = ($urandom_range(0, 3) != 0);
            cyc(v, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                int'($urandom_range(0, 255)), w, int'($urandom_range(0, 7)),
                int'($urandom_range(0, 65535)), "random");
        end
        for (int n = 0; n < 4; n++) cyc(0, 0, 128, 128, 0, 0, 0, "R1 drain");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule